// File: doc/BRIEF.md
# Dual-Image Reload Controller with Fallback Watchdog

This block lets user logic choose which of two stored configuration images is loaded next, and start that reload. Software or a local state machine talks to it through a small word-addressed register port. A selection register holds an override flag and an image index. A control register carries two action bits: one starts a reload and one restarts the watchdog. Both actions can be issued in a single write. The flash access and the configuration engine are outside the block. They are modelled as a fixed busy interval that ends with a one-cycle reload request, and at that request the selected image becomes the running image.

A watchdog guards the application image. Its 12-bit timeout parameter gives the upper bits of a prescaled cycle counter. If the running application image does not restart the counter before the limit, the block forces the factory image, sets a sticky expiry flag and starts a reload by itself. The counter is held at zero while the factory image runs, so a fallback image cannot enter a reboot loop. A build-time switch removes the watchdog completely.

Top module: `img_reload_ctrl`

## Requirements
- R1: Reads return data on `regRdData` in the cycle after the `regRd` strobe, and return zero when no read was made. Address 0, address 2 and addresses 4 to 7 read as zero. Writes to addresses 2 and 4 to 7 change nothing.
- R2: At address 1, bit 0 is the override flag and bit 1 is the image index (0 = application, 1 = factory). `imageIdx` equals the index when the override is set and 0 when it is clear. Reading address 1 returns both bits in [1:0].
- R3: A write to address 0 with bit 0 set, made while `busy` is low, raises `busy` for exactly BUSY_CYCLES cycles. The same write made while `busy` is high is ignored and does not lengthen the interval.
- R4: `reloadReq` is high for exactly one cycle: the first cycle in which `busy` is low again. At that point the image that `imageIdx` shows becomes the running image.
- R5: A write to address 0 with bit 1 set restarts the watchdog count. Writing the value 3 both restarts the watchdog and starts a reload.
- R6: While the application image runs and `busy` is low, the counter restarts at a service write, at the reload request and at reset. If no service write arrives, it fires at the (LIMIT+1)-th clock edge after the restart, where LIMIT = WDOG_TIMEOUT << PRESCALE_SH. When it fires, `busy` rises, the selection becomes override with the factory index (address 1 reads 3), and `wdogExpired` is set.
- R7: A service write captured on the same edge on which the watchdog would fire stops the expiry and starts a new full count.
- R8: While the factory image runs, the watchdog never fires and no reload starts by itself.
- R9: Address 3 reads `busy` in bit 0 and the sticky expiry flag in bit 1. Only reset clears the flag.
- R10: With WDOG_EN = 0 the watchdog never fires and service writes have no effect.
- R11: After reset `busy`, `reloadReq`, `imageIdx` and `wdogExpired` are all 0, and the running image is the application image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Word address of the register access |
| regWrData | input | 32 | Write data |
| regWr | input | 1 | Single-cycle write strobe |
| regRd | input | 1 | Single-cycle read strobe |
| regRdData | output | 32 | Read data, valid one cycle after the read strobe |
| reloadReq | output | 1 | One-cycle request to load the selected image |
| imageIdx | output | 1 | Image the next reload will load (0 application, 1 factory) |
| busy | output | 1 | Reload interval in progress |
| wdogExpired | output | 1 | Sticky flag: the watchdog has fired |

## Verification
Two functions can meet on the same clock edge: the watchdog reaching its limit, and a service write from the running image. The bench waits for a reload to finish, counts exactly LIMIT cycles from the request, and then places a service write so that it is captured on the edge on which expiry would occur. The result is judged at the ports. `busy` must stay low on that edge. It must then stay low for LIMIT more cycles and rise exactly one cycle later, which shows that the service write restarted the count and was not merely ignored. A second instance built with the watchdog disabled receives the same bus traffic and must never expire.

// File: rtl/img_reload_pkg.sv
package img_reload_pkg;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_SEL  = 3'd1;
  localparam logic [2:0] ADDR_STAT = 3'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic       wdSvc;
    logic       selWr;
    logic [1:0] selVal;
    logic       reqFire;
    logic       rdEn;
    logic [2:0] rdAddr;
  } ctlStb_t;

endpackage

// File: rtl/img_reload_ctl.sv
module img_reload_ctl
  import img_reload_pkg::*;
#(
  parameter int BUSY_CYCLES = 16,
  parameter bit WDOG_EN     = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regAddr,
  input  logic [1:0] wrBits,
  input  logic       regWr,
  input  logic       regRd,
  input  logic       wdExpire,
  output ctlStb_t    stb,
  output logic       busy,
  output logic       reloadReq
);

  localparam int BW = $clog2(BUSY_CYCLES + 1);
  localparam logic [BW-1:0] BUSY_LAST = BW'(BUSY_CYCLES - 1);

  logic [BW-1:0] busyCnt;
  logic wrCtrl, trigOk, startBusy, doneNow;

  always_comb begin
    wrCtrl      = regWr && (regAddr == ADDR_CTRL);
    trigOk      = wrCtrl && wrBits[0] && !busy;
    startBusy   = !busy && (trigOk || wdExpire);
    doneNow     = busy && (busyCnt == '0);
    stb.wdSvc   = WDOG_EN && wrCtrl && wrBits[1];
    stb.selWr   = regWr && (regAddr == ADDR_SEL);
    stb.selVal  = wrBits;
    stb.reqFire = doneNow;
    stb.rdEn    = regRd;
    stb.rdAddr  = regAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      busyCnt   <= '0;
      reloadReq <= 1'b0;
    end else begin
      reloadReq <= doneNow;
      if (startBusy) begin
        busy    <= 1'b1;
        busyCnt <= BUSY_LAST;
      end else if (doneNow) begin
        busy <= 1'b0;
      end else if (busy) begin
        busyCnt <= busyCnt - 1'b1;
      end
    end
  end

  // R4
  req_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    reloadReq |=> !reloadReq);
  // R4
  req_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> reloadReq);
  // R4
  req_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    reloadReq |-> !busy);

endmodule

// File: rtl/img_reload_dp.sv
module img_reload_dp
  import img_reload_pkg::*;
#(
  parameter bit          WDOG_EN      = 1'b1,
  parameter logic [11:0] WDOG_TIMEOUT = 12'd200,
  parameter int          PRESCALE_SH  = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStb_t     stb,
  input  logic        busy,
  output logic        wdExpire,
  output logic        imageIdx,
  output logic        wdogExpired,
  output logic [31:0] regRdData
);

  logic selOvr, selIdx, activeImg;

  assign imageIdx = selOvr & selIdx;

  generate
    if (WDOG_EN) begin : g_wd
      localparam int CW = 12 + PRESCALE_SH;
      localparam logic [CW-1:0] LIMIT = CW'(WDOG_TIMEOUT) << PRESCALE_SH;
      logic [CW-1:0] wdCnt;
      logic hold;
      assign hold     = activeImg || busy || stb.wdSvc;
      assign wdExpire = !hold && (wdCnt == LIMIT);
      always_ff @(posedge clk) begin
        if (!rstN)                wdCnt <= '0;
        else if (hold || wdExpire) wdCnt <= '0;
        else                      wdCnt <= wdCnt + 1'b1;
      end
    end else begin : g_nowd
      assign wdExpire = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selOvr      <= 1'b0;
      selIdx      <= 1'b0;
      activeImg   <= 1'b0;
      wdogExpired <= 1'b0;
      regRdData   <= '0;
    end else begin
      if (wdExpire) begin
        selOvr      <= 1'b1;
        selIdx      <= 1'b1;
        wdogExpired <= 1'b1;
      end else if (stb.selWr) begin
        selOvr <= stb.selVal[0];
        selIdx <= stb.selVal[1];
      end
      if (stb.reqFire) activeImg <= imageIdx;
      regRdData <= '0;
      if (stb.rdEn) begin
        case (stb.rdAddr)
          ADDR_SEL:  regRdData <= {30'd0, selIdx, selOvr};
          ADDR_STAT: regRdData <= {30'd0, wdogExpired, busy};
          default:   regRdData <= '0;
        endcase
      end
    end
  end

  // R6
  expire_forces_factory_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdogExpired) |-> (imageIdx && busy));
  // R9
  expired_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdogExpired |=> wdogExpired);
  // R8
  no_expire_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdExpire |-> (!busy && !activeImg));
  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !WDOG_EN |-> !wdogExpired);

endmodule

// File: rtl/img_reload_ctrl.sv
module img_reload_ctrl
  import img_reload_pkg::*;
#(
  parameter bit          WDOG_EN      = 1'b1,
  parameter logic [11:0] WDOG_TIMEOUT = 12'd200,
  parameter int          PRESCALE_SH  = 8,
  parameter int          BUSY_CYCLES  = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  input  logic        regWr,
  input  logic        regRd,
  output logic [31:0] regRdData,
  output logic        reloadReq,
  output logic        imageIdx,
  output logic        busy,
  output logic        wdogExpired
);

  ctlStb_t stb;
  logic wdExpire;
  logic unusedWrHi;

  assign unusedWrHi = ^regWrData[31:2];

  img_reload_ctl #(.BUSY_CYCLES(BUSY_CYCLES), .WDOG_EN(WDOG_EN)) uCtl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrBits(regWrData[1:0]),
    .regWr(regWr), .regRd(regRd), .wdExpire(wdExpire), .stb(stb),
    .busy(busy), .reloadReq(reloadReq)
  );

  img_reload_dp #(.WDOG_EN(WDOG_EN), .WDOG_TIMEOUT(WDOG_TIMEOUT),
                  .PRESCALE_SH(PRESCALE_SH)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .wdExpire(wdExpire),
    .imageIdx(imageIdx), .wdogExpired(wdogExpired), .regRdData(regRdData)
  );

endmodule

// File: tb/sim_img_reload_ctrl.sv
module sim_img_reload_ctrl;

  localparam int BUSYC = 4;
  localparam int LIM   = 20;   // 5 << 2

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [31:0] rdA, rdB;
  logic reqA, idxA, busyA, expA, reqB, idxB, busyB, expB;

  img_reload_ctrl #(.WDOG_EN(1'b1), .WDOG_TIMEOUT(12'd5), .PRESCALE_SH(2),
                    .BUSY_CYCLES(BUSYC)) u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWr(regWr), .regRd(regRd), .regRdData(rdA), .reloadReq(reqA),
    .imageIdx(idxA), .busy(busyA), .wdogExpired(expA));

  img_reload_ctrl #(.WDOG_EN(1'b0), .WDOG_TIMEOUT(12'd5), .PRESCALE_SH(2),
                    .BUSY_CYCLES(BUSYC)) u1 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWr(regWr), .regRd(regRd), .regRdData(rdB), .reloadReq(reqB),
    .imageIdx(idxB), .busy(busyB), .wdogExpired(expB));

  int nCmp = 0, nBad = 0;
  logic [31:0] expQ[$];
  string tagQ[$];
  logic rdSeen = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    nCmp++;
    if (act !== expv) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    expQ.push_back(e); tagQ.push_back(tag);
    regAddr = a; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(posedge clk) rdSeen <= regRd;
  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) chk("R1 unexpected read", rdA, 32'hx);
      else chk(tagQ.pop_front(), rdA, expQ.pop_front());
    end
  end

  initial begin
    #2000000;
    nBad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    int seenBusy;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R11 busy after reset", busyA, 0);
    chk("R11 req after reset", reqA, 0);
    chk("R11 imageIdx after reset", idxA, 0);
    chk("R11 expired after reset", expA, 0);
    wr(0, 2);
    rd(3, 0, "R9 status after reset");
    rd(1, 0, "R2 select after reset");
    rd(0, 0, "R1 ctrl reads zero");
    wr(1, 3);
    chk("R2 override factory", idxA, 1);
    rd(1, 3, "R2 readback 3");
    wr(1, 2);
    chk("R2 no override gives application", idxA, 0);
    rd(1, 2, "R2 readback 2");
    wr(1, 1);
    chk("R2 override application", idxA, 0);
    wr(0, 2);
    // R3 trigger and ignored retrigger
    wr(0, 1);
    chk("R3 busy rises", busyA, 1);
    wr(0, 1);
    step(1); chk("R3 busy cycle 3", busyA, 1);
    step(1); chk("R3 busy cycle 4, retrigger ignored", busyA, 1);
    step(1); chk("R4 busy low at request", busyA, 0);
    chk("R4 request pulse", reqA, 1);
    chk("R10 disabled copy reloads too", reqB, 1);
    step(1); chk("R4 request one cycle", reqA, 0);
    // R5 service keeps watchdog quiet
    step(15); wr(0, 2); step(15);
    chk("R5 serviced, no busy", busyA, 0);
    chk("R5 serviced, no expiry", expA, 0);
    wr(0, 3);
    chk("R5 value 3 starts reload", busyA, 1);
    step(4); chk("R5 value 3 reload request", reqA, 1);
    // R6 expiry
    wr(0, 2);
    step(LIM);
    chk("R6 no expiry at limit edge", busyA, 0);
    chk("R6 flag still clear", expA, 0);
    step(1);
    chk("R6 busy on expiry", busyA, 1);
    chk("R6 expired flag", expA, 1);
    chk("R6 factory forced", idxA, 1);
    chk("R10 disabled never busy", busyB, 0);
    chk("R10 disabled never expires", expB, 0);
    step(4); chk("R6 fallback request", reqA, 1);
    rd(3, 2, "R9 sticky flag, not busy");
    rd(1, 3, "R6 selection reads 3");
    // R8 factory running: quiet
    seenBusy = 0;
    for (int i = 0; i < 3 * LIM; i++) begin
      @(negedge clk);
      if (busyA || reqA) seenBusy++;
    end
    chk("R8 factory image never reloads", seenBusy, 0);
    // R7 collision of service and expiry
    wr(1, 1);
    wr(0, 1);
    step(4); chk("R7 setup reload to application", reqA, 1);
    step(LIM);
    wr(0, 2);
    chk("R7 service on limit edge wins", busyA, 0);
    step(LIM);
    chk("R7 restarted count, no early expiry", busyA, 0);
    step(1);
    chk("R7 expiry after full new count", busyA, 1);
    step(6);
    // R1 unmapped
    wr(5, 1);
    chk("R1 write to 5 ignored", busyA, 0);
    wr(2, 1);
    chk("R1 write to 2 ignored", busyA, 0);
    rd(5, 0, "R1 addr 5 reads zero");
    rd(2, 0, "R1 addr 2 reads zero");
    rd(1, 3, "R1 selection untouched by addr 5");
    rd(3, 2, "R9 flag stays set");
    step(1);
    chk("R1 no data without read", rdA, 0);
    step(2);
    chk("R1 scoreboard drained", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule